// File: doc/BRIEF.md
# Watermark FIFO Start Controller

This block sits between a frame serialiser, a DMA engine and two 128-byte byte FIFOs, one for transmit and one for receive. It keeps the occupancy of both FIFOs from per-byte push and pop strobes. From those counts it decides two things: when a DMA burst may be requested in each direction, and when the serialiser may begin putting the current transmit frame onto the line. A single 2-bit watermark code sets all three thresholds. An early-start bit chooses between a start taken from the free space left in the FIFO and a start taken from the bytes already written.

The DMA engine sees a request line per direction. Each request stays high until it is acknowledged and then stays low until the burst-done strobe. The serialiser sees a one-cycle start pulse and pops bytes after it. If the serialiser pops from an empty FIFO before the frame's last byte has arrived, the block raises an underrun pulse. It then throws away the rest of that frame as the DMA writes it. Configuration writes go into a shadow register. The thresholds only pick them up while no transmit frame is in progress.

Top module: `wmrk_fifo_start`

## Requirements
- R1: The active watermark W equals (code+1)*8 bytes, so codes 0, 1, 2 and 3 give 8, 16, 24 and 32. The receive burst threshold shows it: 23 bytes stay below code 2, and 24 bytes reach it.
- R2: The receive condition is true when the receive level is at least W, or when at least one byte pushed with its end-of-frame flag set is still held. Receive requests open only on this condition.
- R3: The transmit condition is true when the free space (128 minus the transmit level) is at least W and the current frame's end-of-frame byte has not been written yet. Transmit requests open only on this condition.
- R4: A request FSM that is idle and sees its condition true raises its request on the next cycle. The request stays high until ack, then stays low until done. The condition is evaluated again in the cycle after done, so a request reappears at the earliest two cycles after the done edge.
- R5: With early-start clear, tx_start_o is high for exactly one cycle, in the first cycle where the transmit level of the filling frame is at least 128-W (120, 112, 104 or 96).
- R6: With early-start set, tx_start_o pulses in the first cycle where the filling frame holds at least W bytes.
- R7: If the frame's end-of-frame byte is already in the FIFO, tx_start_o pulses at once, whatever the threshold.
- R8: A transmit pop while sending, with the level at 0 and end-of-frame not yet written, raises tx_underrun_o for one cycle in the following cycle. After that, pushes are discarded and leave the level at 0, up to and including the push flagged end-of-frame. The next push then starts a new frame.
- R9: A configuration write takes effect only while the transmitter is idle. A write made during a frame does not move that frame's start point; it applies from the next frame.
- R10: Each level moves up by 1 for an accepted push and down by 1 for an accepted pop. A push to a full FIFO (128) is ignored. A receive pop at level 0 is ignored. Transmit pops count only while sending.
- R11: Reset clears both levels, both requests, the underrun pulse and the start state. Watermark code 0 with early-start clear becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the shadow configuration |
| cfg_wmrk_i | input | 2 | Watermark code |
| cfg_early_i | input | 1 | Early-start mode bit |
| tx_push_i | input | 1 | DMA writes one byte into the transmit FIFO |
| tx_push_eof_i | input | 1 | The byte being pushed is the last one of its frame |
| tx_pop_i | input | 1 | Serialiser takes one byte from the transmit FIFO |
| rx_push_i | input | 1 | Receiver writes one byte into the receive FIFO |
| rx_push_eof_i | input | 1 | The byte being pushed ends a received frame |
| rx_pop_i | input | 1 | DMA reads one byte from the receive FIFO |
| rx_pop_eof_i | input | 1 | The byte being popped ends a received frame |
| tx_dma_ack_i | input | 1 | DMA accepts the transmit burst request |
| tx_dma_done_i | input | 1 | Transmit burst finished |
| rx_dma_ack_i | input | 1 | DMA accepts the receive burst request |
| rx_dma_done_i | input | 1 | Receive burst finished |
| tx_dma_req_o | output | 1 | Transmit burst request |
| rx_dma_req_o | output | 1 | Receive burst request |
| tx_start_o | output | 1 | One-cycle pulse: frame transmission may begin |
| tx_underrun_o | output | 1 | One-cycle pulse: transmit underrun, frame aborted |
| tx_level_o | output | 8 | Transmit FIFO occupancy in bytes |
| rx_level_o | output | 8 | Receive FIFO occupancy in bytes |

## Verification
A miscount in either level register shows up on tx_level_o or rx_level_o in the very next cycle. It then moves the request and start decisions, which the cycle-level reference model compares on every clock. A transmit frame state left stuck in the wrong phase shows up as a missing or repeated start pulse, an underrun that never clears its discard phase, or pushes that vanish from the level. A shadow configuration copied at the wrong time moves the start pulse by whole bytes. The frame that is written mid-stream is built so that the wrong copy starts 24 bytes early.

// File: rtl/wmrk_pkg.sv
package wmrk_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_FILL,
    TX_SEND,
    TX_DROP
  } tx_state_e;

  typedef enum logic [1:0] {
    BR_IDLE,
    BR_WAIT,
    BR_BUSY
  } burst_state_e;

  function automatic int unsigned wm_bytes(input logic [1:0] code, input int unsigned step);
    return (32'(code) + 32'd1) * step;
  endfunction

endpackage

// File: rtl/wmrk_level_cnt.sv
module wmrk_level_cnt #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [LVL_W-1:0] level_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= '0;
    end else if (inc_i && !dec_i) begin
      level_o <= level_o + LVL_W'(1);
    end else if (dec_i && !inc_i) begin
      level_o <= level_o - LVL_W'(1);
    end
  end

endmodule

// File: rtl/wmrk_burst_req.sv
module wmrk_burst_req
  import wmrk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic ack_i,
  input  logic done_i,
  output logic req_o
);

  burst_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BR_IDLE: if (cond_i) st_d = BR_WAIT;
      BR_WAIT: if (ack_i)  st_d = BR_BUSY;
      BR_BUSY: if (done_i) st_d = BR_IDLE;
      default: st_d = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= BR_IDLE;
    else         st_q <= st_d;
  end

  assign req_o = (st_q == BR_WAIT);

endmodule

// File: rtl/wmrk_tx_start.sv
module wmrk_tx_start
  import wmrk_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] wm_i,
  input  logic             early_i,
  input  logic             push_i,
  input  logic             push_eof_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             start_o,
  output logic             underrun_o,
  output logic             idle_o,
  output logic             eof_seen_o
);

  tx_state_e        st_q, st_d;
  logic             eof_q, eof_d;
  logic             und_q;
  logic [LVL_W-1:0] thr;
  logic             full, empty, und_now, last_pop;

  // early: bytes written; normal: free space down to wm
  assign thr   = early_i ? wm_i : (LVL_W'(DEPTH) - wm_i);
  assign full  = (level_i == LVL_W'(DEPTH));
  assign empty = (level_i == '0);

  assign und_now   = pop_i && (st_q == TX_SEND) && empty && !eof_q;
  assign push_ok_o = push_i && !full && !eof_q && (st_q != TX_DROP) && !und_now;
  assign pop_ok_o  = pop_i && (st_q == TX_SEND) && !empty;
  assign last_pop  = pop_ok_o && eof_q && (level_i == LVL_W'(1));
  assign start_o   = (st_q == TX_FILL) && (eof_q || (level_i >= thr));

  always_comb begin
    st_d  = st_q;
    eof_d = eof_q;
    unique case (st_q)
      TX_IDLE: begin
        if (push_ok_o) begin
          st_d  = TX_FILL;
          eof_d = push_eof_i;
        end
      end
      TX_FILL: begin
        if (start_o) st_d = TX_SEND;
        if (push_ok_o && push_eof_i) eof_d = 1'b1;
      end
      TX_SEND: begin
        if (und_now) begin
          st_d = TX_DROP;
        end else if (last_pop) begin
          st_d  = TX_IDLE;
          eof_d = 1'b0;
        end else if (push_ok_o && push_eof_i) begin
          eof_d = 1'b1;
        end
      end
      TX_DROP: begin
        if (push_i && push_eof_i) st_d = TX_IDLE;
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      eof_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      eof_q <= eof_d;
      und_q <= und_now;
    end
  end

  assign underrun_o = und_q;
  assign idle_o     = (st_q == TX_IDLE);
  assign eof_seen_o = eof_q;

endmodule

// File: rtl/wmrk_fifo_start.sv
module wmrk_fifo_start
  import wmrk_pkg::*;
#(
  parameter int unsigned DEPTH   = 128,
  parameter int unsigned WM_STEP = 8,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_wmrk_i,
  input  logic             cfg_early_i,
  input  logic             tx_push_i,
  input  logic             tx_push_eof_i,
  input  logic             tx_pop_i,
  input  logic             rx_push_i,
  input  logic             rx_push_eof_i,
  input  logic             rx_pop_i,
  input  logic             rx_pop_eof_i,
  input  logic             tx_dma_ack_i,
  input  logic             tx_dma_done_i,
  input  logic             rx_dma_ack_i,
  input  logic             rx_dma_done_i,
  output logic             tx_dma_req_o,
  output logic             rx_dma_req_o,
  output logic             tx_start_o,
  output logic             tx_underrun_o,
  output logic [LVL_W-1:0] tx_level_o,
  output logic [LVL_W-1:0] rx_level_o
);

  logic [1:0]       wm_pend_q, wm_act_q;
  logic             early_pend_q, early_act_q;
  logic [LVL_W-1:0] wm;
  logic             tx_idle, tx_eof_seen, tx_push_ok, tx_pop_ok;
  logic             rx_push_ok, rx_pop_ok, rx_eof_inc, rx_eof_dec;
  logic [LVL_W-1:0] rx_eof_cnt;
  logic             tx_cond, rx_cond;

  // shadow config, copied to the active set only between tx frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_pend_q    <= '0;
      early_pend_q <= 1'b0;
      wm_act_q     <= '0;
      early_act_q  <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        wm_pend_q    <= cfg_wmrk_i;
        early_pend_q <= cfg_early_i;
      end
      if (tx_idle) begin
        wm_act_q    <= wm_pend_q;
        early_act_q <= early_pend_q;
      end
    end
  end

  assign wm = LVL_W'(wm_bytes(wm_act_q, WM_STEP));

  // transmit side
  wmrk_tx_start #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx_start (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wm_i       (wm),
    .early_i    (early_act_q),
    .push_i     (tx_push_i),
    .push_eof_i (tx_push_eof_i),
    .pop_i      (tx_pop_i),
    .level_i    (tx_level_o),
    .push_ok_o  (tx_push_ok),
    .pop_ok_o   (tx_pop_ok),
    .start_o    (tx_start_o),
    .underrun_o (tx_underrun_o),
    .idle_o     (tx_idle),
    .eof_seen_o (tx_eof_seen)
  );

  wmrk_level_cnt #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (tx_push_ok),
    .dec_i   (tx_pop_ok),
    .level_o (tx_level_o)
  );

  // receive side
  assign rx_push_ok = rx_push_i && (rx_level_o != LVL_W'(DEPTH));
  assign rx_pop_ok  = rx_pop_i && (rx_level_o != '0);
  assign rx_eof_inc = rx_push_ok && rx_push_eof_i;
  assign rx_eof_dec = rx_pop_ok && rx_pop_eof_i && (rx_eof_cnt != '0);

  wmrk_level_cnt #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (rx_push_ok),
    .dec_i   (rx_pop_ok),
    .level_o (rx_level_o)
  );

  wmrk_level_cnt #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx_eofs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (rx_eof_inc),
    .dec_i   (rx_eof_dec),
    .level_o (rx_eof_cnt)
  );

  // burst conditions and request handshakes
  assign tx_cond = ((LVL_W'(DEPTH) - tx_level_o) >= wm) && !tx_eof_seen;
  assign rx_cond = (rx_level_o >= wm) || (rx_eof_cnt != '0);

  wmrk_burst_req u_tx_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (tx_cond),
    .ack_i  (tx_dma_ack_i),
    .done_i (tx_dma_done_i),
    .req_o  (tx_dma_req_o)
  );

  wmrk_burst_req u_rx_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (rx_cond),
    .ack_i  (rx_dma_ack_i),
    .done_i (rx_dma_done_i),
    .req_o  (rx_dma_req_o)
  );

endmodule

// File: rtl/wmrk_fifo_start_chk.sv
module wmrk_fifo_start_chk #(
  parameter int unsigned DEPTH   = 128,
  parameter int unsigned WM_STEP = 8,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_start_o,
  input logic             tx_underrun_o,
  input logic             tx_dma_req_o,
  input logic             rx_dma_req_o,
  input logic             tx_dma_ack_i,
  input logic             rx_dma_ack_i,
  input logic             rx_push_i,
  input logic             rx_pop_i,
  input logic [LVL_W-1:0] tx_level_o,
  input logic [LVL_W-1:0] rx_level_o,
  input logic [LVL_W-1:0] rx_eof_cnt,
  input logic             tx_eof_seen
);

  AST_TX_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_req_o && !tx_dma_ack_i |=> tx_dma_req_o); // R4

  AST_RX_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o && !rx_dma_ack_i |=> rx_dma_req_o); // R4

  AST_RX_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dma_req_o) |-> ($past(rx_level_o) >= LVL_W'(WM_STEP) || $past(rx_eof_cnt) != '0)); // R2

  AST_TX_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_dma_req_o) |-> $past(tx_level_o) <= LVL_W'(DEPTH - WM_STEP)); // R3

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o); // R5

  AST_START_FILLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (tx_level_o >= LVL_W'(WM_STEP) || tx_eof_seen)); // R6

  AST_UNDERRUN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underrun_o |=> !tx_underrun_o); // R8

  AST_UNDERRUN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underrun_o |-> tx_level_o == '0); // R8

  AST_RX_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_push_i && !rx_pop_i |=> $stable(rx_level_o)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level_o <= LVL_W'(DEPTH) && rx_level_o <= LVL_W'(DEPTH)); // R10

endmodule

bind wmrk_fifo_start wmrk_fifo_start_chk #(.DEPTH(DEPTH), .WM_STEP(WM_STEP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_start_o    (tx_start_o),
  .tx_underrun_o (tx_underrun_o),
  .tx_dma_req_o  (tx_dma_req_o),
  .rx_dma_req_o  (rx_dma_req_o),
  .tx_dma_ack_i  (tx_dma_ack_i),
  .rx_dma_ack_i  (rx_dma_ack_i),
  .rx_push_i     (rx_push_i),
  .rx_pop_i      (rx_pop_i),
  .tx_level_o    (tx_level_o),
  .rx_level_o    (rx_level_o),
  .rx_eof_cnt    (rx_eof_cnt),
  .tx_eof_seen   (tx_eof_seen)
);

// File: tb/wmrk_fifo_start_tb_top.sv
module wmrk_fifo_start_tb_top;

  localparam int DEPTH = 128;
  localparam int STEP  = 8;
  localparam int LW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_we = 0, cfg_early = 0;
  logic [1:0]    cfg_wm = 0;
  logic          tx_push = 0, tx_push_eof = 0, tx_pop = 0;
  logic          rx_push = 0, rx_push_eof = 0, rx_pop = 0, rx_pop_eof = 0;
  logic          tx_ack = 0, tx_done = 0, rx_ack = 0, rx_done = 0;
  logic          tx_req, rx_req, tx_start, tx_und;
  logic [LW-1:0] tx_lvl, rx_lvl;

  wmrk_fifo_start #(.DEPTH(DEPTH), .WM_STEP(STEP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wmrk_i(cfg_wm), .cfg_early_i(cfg_early),
    .tx_push_i(tx_push), .tx_push_eof_i(tx_push_eof), .tx_pop_i(tx_pop),
    .rx_push_i(rx_push), .rx_push_eof_i(rx_push_eof), .rx_pop_i(rx_pop), .rx_pop_eof_i(rx_pop_eof),
    .tx_dma_ack_i(tx_ack), .tx_dma_done_i(tx_done), .rx_dma_ack_i(rx_ack), .rx_dma_done_i(rx_done),
    .tx_dma_req_o(tx_req), .rx_dma_req_o(rx_req), .tx_start_o(tx_start), .tx_underrun_o(tx_und),
    .tx_level_o(tx_lvl), .rx_level_o(rx_lvl)
  );

  int  n_chk = 0, n_err = 0;
  bit  finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 filling, 2 sending, 3 discarding
  int m_pend, m_pend_e, m_act, m_act_e;
  int m_tst, m_eof, m_txl, m_rxl, m_rxe, m_und, m_trq, m_rrq;

  function automatic int req_step(int st, bit cond, bit ack, bit done);
    if (st == 0 && cond) return 1;
    if (st == 1 && ack)  return 2;
    if (st == 2 && done) return 0;
    return st;
  endfunction

  function automatic int thr_of(int code, int early);
    return early != 0 ? (code + 1) * STEP : DEPTH - (code + 1) * STEP;
  endfunction

  always @(posedge clk) begin : model
    int wm, n_st, n_eof;
    bit tpush, tpop, und, tcond, rcond, rpush, rpop, start;
    if (!rst_n) begin
      m_pend = 0; m_pend_e = 0; m_act = 0; m_act_e = 0;
      m_tst = 0; m_eof = 0; m_txl = 0; m_rxl = 0; m_rxe = 0;
      m_und = 0; m_trq = 0; m_rrq = 0;
    end else begin
      wm    = (m_act + 1) * STEP;
      und   = tx_pop && m_tst == 2 && m_txl == 0 && m_eof == 0;
      tpush = tx_push && m_txl < DEPTH && m_eof == 0 && m_tst != 3 && !und;
      tpop  = tx_pop && m_tst == 2 && m_txl > 0;
      start = m_tst == 1 && (m_eof != 0 || m_txl >= thr_of(m_act, m_act_e));
      tcond = (DEPTH - m_txl) >= wm && m_eof == 0;
      rcond = m_rxl >= wm || m_rxe > 0;
      rpush = rx_push && m_rxl < DEPTH;
      rpop  = rx_pop && m_rxl > 0;
      n_st = m_tst; n_eof = m_eof;
      case (m_tst)
        0: if (tpush) begin n_st = 1; n_eof = tx_push_eof; end
        1: begin if (start) n_st = 2; if (tpush && tx_push_eof) n_eof = 1; end
        2: if (und) n_st = 3;
           else if (tpop && m_txl == 1 && m_eof != 0) begin n_st = 0; n_eof = 0; end
           else if (tpush && tx_push_eof) n_eof = 1;
        default: if (tx_push && tx_push_eof) n_st = 0;
      endcase
      m_trq = req_step(m_trq, tcond, tx_ack, tx_done);
      m_rrq = req_step(m_rrq, rcond, rx_ack, rx_done);
      if (m_tst == 0) begin m_act = m_pend; m_act_e = m_pend_e; end
      if (cfg_we) begin m_pend = cfg_wm; m_pend_e = cfg_early; end
      m_und = und;
      m_txl = m_txl + int'(tpush) - int'(tpop);
      if (rpop && rx_pop_eof && m_rxe > 0) m_rxe--;
      if (rpush && rx_push_eof) m_rxe++;
      m_rxl = m_rxl + int'(rpush) - int'(rpop);
      m_tst = n_st; m_eof = n_eof;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R10 tx level", int'(tx_lvl), m_txl);
      chk("R10 rx level", int'(rx_lvl), m_rxl);
      chk("R3 tx request", int'(tx_req), int'(m_trq == 1));
      chk("R2 rx request", int'(rx_req), int'(m_rrq == 1));
      chk("R5 tx start", int'(tx_start),
          int'(m_tst == 1 && (m_eof != 0 || m_txl >= thr_of(m_act, m_act_e))));
      chk("R8 underrun", int'(tx_und), m_und);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cfg(input int code, input bit early);
    cfg_we = 1; cfg_wm = 2'(code); cfg_early = early; tick(); cfg_we = 0;
  endtask

  task automatic txp(input int n, input bit eof_last);
    for (int i = 0; i < n; i++) begin
      tx_push = 1; tx_push_eof = eof_last && (i == n - 1); tick();
    end
    tx_push = 0; tx_push_eof = 0;
  endtask

  task automatic txq(input int n);
    for (int i = 0; i < n; i++) begin tx_pop = 1; tick(); end
    tx_pop = 0;
  endtask

  task automatic rxp(input int n, input bit eof_last);
    for (int i = 0; i < n; i++) begin
      rx_push = 1; rx_push_eof = eof_last && (i == n - 1); tick();
    end
    rx_push = 0; rx_push_eof = 0;
  endtask

  task automatic rxq(input int n, input bit eof_last);
    for (int i = 0; i < n; i++) begin
      rx_pop = 1; rx_pop_eof = eof_last && (i == n - 1); tick();
    end
    rx_pop = 0; rx_pop_eof = 0;
  endtask

  task automatic pulse_tx_ack();  tx_ack = 1;  tick(); tx_ack = 0;  endtask
  task automatic pulse_tx_done(); tx_done = 1; tick(); tx_done = 0; endtask
  task automatic pulse_rx_ack();  rx_ack = 1;  tick(); rx_ack = 0;  endtask
  task automatic pulse_rx_done(); rx_done = 1; tick(); rx_done = 0; endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: outputs cleared while reset is held
    chk("R11 tx level", int'(tx_lvl), 0);
    chk("R11 rx level", int'(rx_lvl), 0);
    chk("R11 tx req", int'(tx_req), 0);
    chk("R11 rx req", int'(rx_req), 0);
    chk("R11 start", int'(tx_start), 0);
    chk("R11 underrun", int'(tx_und), 0);
    rst_n = 1;

    // R4: empty tx FIFO wants a burst; request held, dropped on ack, back after done
    tick(3);
    chk("R4 held without ack", int'(tx_req), 1);
    pulse_tx_ack();
    chk("R4 low after ack", int'(tx_req), 0);
    tick(2);
    chk("R4 low during burst", int'(tx_req), 0);
    pulse_tx_done();
    chk("R4 idle cycle after done", int'(tx_req), 0);
    tick();
    chk("R4 re-evaluated after done", int'(tx_req), 1);

    // R1/R2: code 2 -> 24 bytes
    cfg(2, 0); tick(2);
    rxp(23, 0); tick(2);
    chk("R1 rx below 24", int'(rx_req), 0);
    rxp(1, 0); tick();
    chk("R1 rx at 24", int'(rx_req), 1);
    pulse_rx_ack();
    rxq(24, 0);
    pulse_rx_done(); tick();
    chk("R4 rx req low when empty", int'(rx_req), 0);
    rxp(3, 1); tick();
    chk("R2 rx eof below watermark", int'(rx_req), 1);
    pulse_rx_ack();
    rxq(3, 1);
    pulse_rx_done(); tick(2);
    chk("R2 rx idle after eof drained", int'(rx_req), 0);

    // R10: pop on empty ignored, push on full ignored
    rxq(2, 0);
    chk("R10 rx pop at empty", int'(rx_lvl), 0);
    rxp(130, 0);
    chk("R10 rx push at full", int'(rx_lvl), 128);
    rxq(128, 0);

    // R5: normal start at 120 with code 0
    cfg(0, 0); tick(2);
    txp(119, 0);
    chk("R5 no start at 119", int'(tx_start), 0);
    txp(1, 0);
    chk("R5 start at 120", int'(tx_start), 1);
    tick();
    chk("R5 single cycle", int'(tx_start), 0);
    txp(1, 1);
    txq(121);
    chk("R10 tx drained", int'(tx_lvl), 0);

    // R9: mid-frame write of code 3 must not start this frame at 96
    txp(1, 0);
    cfg(3, 0);
    txp(95, 0);
    chk("R9 mid-frame write ignored", int'(tx_start), 0);
    txp(23, 0);
    chk("R9 no start at 119", int'(tx_start), 0);
    txp(1, 0);
    chk("R9 old threshold 120", int'(tx_start), 1);
    tick();
    txp(1, 1);
    txq(121);
    txp(95, 0);
    chk("R9 next frame below 96", int'(tx_start), 0);
    txp(1, 0);
    chk("R9 next frame starts at 96", int'(tx_start), 1);
    tick();
    txp(1, 1);
    txq(97);

    // R6: early start, code 1 -> 16 bytes
    cfg(1, 1); tick(2);
    txp(15, 0);
    chk("R6 early below 16", int'(tx_start), 0);
    txp(1, 0);
    chk("R6 early at 16", int'(tx_start), 1);
    tick();
    txp(1, 1);
    txq(17);

    // R7 + R3: short frame with eof starts at once; no tx burst while eof held
    cfg(0, 0); tick(2);
    txp(5, 1);
    chk("R7 short frame start", int'(tx_start), 1);
    pulse_tx_ack(); pulse_tx_done(); tick(2);
    chk("R3 no request after eof", int'(tx_req), 0);
    txq(5); tick();
    chk("R3 request after frame done", int'(tx_req), 1);

    // R8: early code 0, underrun and discard
    cfg(0, 1); tick(2);
    txp(8, 0);
    chk("R6 early at 8", int'(tx_start), 1);
    tick();
    txq(8);
    chk("R8 level empty before underrun", int'(tx_und), 0);
    txq(1);
    chk("R8 underrun pulse", int'(tx_und), 1);
    txp(3, 0);
    chk("R8 pushes discarded", int'(tx_lvl), 0);
    txp(1, 1);
    chk("R8 eof push discarded", int'(tx_lvl), 0);
    txp(8, 0);
    chk("R8 new frame after abort", int'(tx_start), 1);
    tick();
    txp(1, 1);
    txq(9);
    tick(4);
    chk("R10 final tx level", int'(tx_lvl), 0);
    summary();
  end

endmodule